// File: doc/BRIEF.md
# Bus Transaction Error Status Register

This block sits beside a slave port on an on-chip packet interconnect and watches each incoming request. It recognises two error classes: a read or write that carries more than one data beat (an oversized transfer), and a request whose type the slave does not handle. Each class owns a sticky flag in a 64-bit status register. An armed class also feeds a level error output towards the system, and sets the exception bit of the response that the slave returns for the offending request.

The enables are active-low, so both classes are armed straight out of reset. Software reads the register at any time. It clears a flag by writing 1 to that flag's bit, and it writes the two enable bits as ordinary storage. The error output is held for as long as an armed flag stays set, so it drops only when software clears that flag or disarms its class.

Top module: `txn_err_reg`

## Requirements
- R1: After reset `reg_rdata` is all zeros, and `err_out`, `rsp_valid` and `rsp_excep` are 0.
- R2: `reg_rdata` places the oversize flag at bit 33, the bad-type flag at bit 32, the oversize enable at bit 1 and the bad-type enable at bit 0. Every other bit reads 0, and writing 1s to those other bits has no effect.
- R3: A valid request of type read (1) or write (2) whose `req_size` is 1 (16 bytes) or 2 (32 bytes) sets bit 33 at the next clock edge when bit 1 is 0. Size 0 (8 bytes) and size 3 do not set it, and neither do other types.
- R4: A valid request of type 0 (null), 3 (exclusive burst start), 4 (snoop), 5 (peek write) or 6 (debug) sets bit 32 at the next clock edge when bit 0 is 0. Types 1, 2 and 7 (peek read) do not set it.
- R5: While an enable bit is 1, its class neither sets its flag nor raises `err_out` nor marks `rsp_excep`.
- R6: Flags are sticky. A register write with 1 in a flag bit clears that flag. A 0 in a flag bit leaves the flag unchanged.
- R7: When a detected event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R8: `err_out` is 1 exactly when some flag is set while its enable bit is 0.
- R9: A valid request with `req_rsp` high gives `rsp_valid` high one cycle later. `rsp_excep` is high in that same cycle only if the request raised an armed error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_type | input | 3 | Request type code |
| req_size | input | 2 | Transfer size code: 0 = 8 B, 1 = 16 B, 2 = 32 B |
| req_rsp | input | 1 | The request expects a response |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Current register value |
| err_out | output | 1 | Level error signal to the system |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_excep | output | 1 | Exception bit of that response |

## Verification
The embedded properties check, on every cycle, that an armed event sets its flag at the next clock edge. They also check that a flag holds until a clearing write and that a clearing write without a concurrent event empties it. Two further properties check that an exception never appears without a response and that the error output holds while no write occurs. Only the bench's scenarios show the full type and size decode tables, and that disarmed classes stay silent. The same holds for the collision between setting and clearing, for writes to reserved bits, and for the exact exception value per request. The bench covers these by comparing against its own model on every clock.

// File: rtl/txn_err_reg.sv
module txn_err_reg #(
  parameter int TYPE_W = 3,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_rsp,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              err_out,
  output logic              rsp_valid,
  output logic              rsp_excep
);
  logic flag_sz, flag_ut, dis_sz, dis_ut;
  logic is_rw, big, bad_type, ev_sz, ev_ut;

  assign is_rw    = (req_type == TYPE_W'(1)) || (req_type == TYPE_W'(2));
  assign big      = (req_size == SIZE_W'(1)) || (req_size == SIZE_W'(2));
  assign bad_type = (req_type == TYPE_W'(0)) || (req_type == TYPE_W'(3)) ||
                    (req_type == TYPE_W'(4)) || (req_type == TYPE_W'(5)) ||
                    (req_type == TYPE_W'(6));
  assign ev_sz    = req_valid && is_rw && big && !dis_sz;
  assign ev_ut    = req_valid && bad_type && !dis_ut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sz   <= 1'b0;
      flag_ut   <= 1'b0;
      dis_sz    <= 1'b0;
      dis_ut    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_excep <= 1'b0;
    end else begin
      flag_sz   <= ev_sz | (flag_sz & ~(reg_wr & reg_wdata[33]));
      flag_ut   <= ev_ut | (flag_ut & ~(reg_wr & reg_wdata[32]));
      if (reg_wr) begin
        dis_sz <= reg_wdata[1];
        dis_ut <= reg_wdata[0];
      end
      rsp_valid <= req_valid && req_rsp;
      rsp_excep <= req_valid && req_rsp && (ev_sz || ev_ut);
    end
  end

  assign reg_rdata = {30'd0, flag_sz, flag_ut, 30'd0, dis_sz, dis_ut};
  assign err_out   = (flag_sz && !dis_sz) || (flag_ut && !dis_ut);

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[63:34], reg_wdata[31:2]};

  // R3
  sz_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_rw && big && !reg_rdata[1]) |=> reg_rdata[33]);
  // R4
  ut_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_type && !reg_rdata[0]) |=> reg_rdata[32]);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[33] && !(reg_wr && reg_wdata[33])) |=> reg_rdata[33]);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[32] && !ev_ut) |=> !reg_rdata[32]);
  // R9
  excep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_excep |-> rsp_valid);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_out && !reg_wr) |=> err_out);
endmodule

// File: tb/test_txn_err_reg.sv
module test_txn_err_reg;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rsp = 0, reg_wr = 0;
  logic [2:0] req_type = 0;
  logic [1:0] req_size = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic err_out, rsp_valid, rsp_excep;

  txn_err_reg i_txn_err_reg (.*);

  always #10 clk = ~clk;

  int m_sf, m_tf, m_se, m_te, m_rv, m_re;
  int compared = 0, mismatched = 0;
  bit checking = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sf = 0; m_tf = 0; m_se = 0; m_te = 0; m_rv = 0; m_re = 0;
    end else begin
      int sz, ut, sev, tev;
      sz  = req_valid && (req_type inside {1, 2}) && (req_size inside {1, 2});
      ut  = req_valid && (req_type inside {0, 3, 4, 5, 6});
      sev = sz && !m_se;
      tev = ut && !m_te;
      if (reg_wr && reg_wdata[33]) m_sf = 0;
      if (reg_wr && reg_wdata[32]) m_tf = 0;
      if (sev) m_sf = 1;
      if (tev) m_tf = 1;
      m_rv = req_valid && req_rsp;
      m_re = m_rv && (sev || tev);
      if (reg_wr) begin m_se = reg_wdata[1]; m_te = reg_wdata[0]; end
    end
  end

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    logic [63:0] er;
    er = 64'd0;
    er[33] = m_sf[0]; er[32] = m_tf[0]; er[1] = m_se[0]; er[0] = m_te[0];
    cmp("rdata", reg_rdata, er);
    cmp("err_out", 64'(err_out), 64'((m_sf && !m_se) || (m_tf && !m_te)));
    cmp("rsp_valid", 64'(rsp_valid), 64'(m_rv));
    cmp("rsp_excep", 64'(rsp_excep), 64'(m_re));
  end

  task automatic req(input int t, input int s, input bit r);
    req_valid = 1; req_type = 3'(t); req_size = 2'(s); req_rsp = r;
    @(posedge clk); #5;
    req_valid = 0; req_rsp = 0;
  endtask

  task automatic wr(input logic [63:0] d);
    reg_wr = 1; reg_wdata = d;
    @(posedge clk); #5;
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #5;
        checking = 1;
        cur_req = "R1";
        @(negedge clk);
        cmp("reset rdata", reg_rdata, 64'd0);
        #1;
        rst_n = 1;
        idle(2);
        cur_req = "R3";
        for (int t = 1; t <= 2; t++)
          for (int s = 0; s < 4; s++) begin
            req(t, s, 1); idle(1);
            wr(64'h3_0000_0000); idle(1);
          end
        req(7, 2, 1); idle(1);
        cur_req = "R4";
        for (int t = 0; t < 8; t++) begin
          req(t, 0, 1); idle(1);
          wr(64'h3_0000_0000); idle(1);
        end
        cur_req = "R5";
        wr(64'h3);
        req(3, 0, 1); req(1, 2, 1); idle(2);
        wr(64'h1); req(4, 0, 1); req(2, 1, 1); idle(2);
        cur_req = "R8";
        wr(64'h3); idle(2);
        wr(64'h0); idle(2);
        cur_req = "R6";
        wr(64'h0); idle(1);
        wr(64'h2_0000_0000); idle(1);
        wr(64'h1_0000_0000); idle(1);
        cur_req = "R7";
        req(1, 1, 0); req(5, 0, 0);
        reg_wr = 1; reg_wdata = 64'h3_0000_0000;
        req_valid = 1; req_type = 3'd2; req_size = 2'd2;
        @(posedge clk); #5;
        reg_wr = 0; reg_wdata = 0; req_valid = 0;
        idle(1);
        cur_req = "R2";
        wr(64'hFFFF_FFFC_FFFF_FFFC); idle(1);
        wr(64'hFFFF_FFFF_FFFF_FFFF); idle(1);
        wr(64'h0);
        cur_req = "R9";
        req(6, 0, 1); req(6, 0, 0); req(1, 0, 1); req(2, 2, 1);
        req(7, 0, 1); idle(2);
        checking = 0;
      end
      begin
        repeat (5000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule